// File: doc/BRIEF.md
# PHY Power-Up Sequencer with Bounded Waits

This block is a hardware sequencer that takes a serial-link PHY from reset to a running state. It does not need software to step it through the sequence. It drives the PHY reset line, the reference-clock enable and the lane A idle-off control. It also drives a small configuration port: an address, a data nibble and a write strobe. The PLL itself is outside the block. Its lock flag and its output-enable flag arrive as plain inputs.

A caller requests one of four operations. Each request is a single-cycle pulse on its own input, and each operation ends with a one-cycle `done_o` or `err_o` pulse.

- **Init** turns on the reference clock and holds the PHY in reset.
- **Exit** turns off the reference clock.
- **Power-off** first idles lane A and then puts the PHY back into reset.
- **Power-on** runs the long sequence:
  1. Release the reset.
  2. Select configuration address 0x10 and take lane A out of idle.
  3. Wait for PLL lock.
  4. Issue two strobed configuration writes.
  5. Wait for the PLL output flag to clear.
  6. Reselect address 0x10 and wait for lock again.

Every wait checks its condition once per poll interval. It gives up after a fixed time, and each wait has its own error code. A failed wait returns the PHY to reset.

States:

| State | Action or waiting condition |
|-------|-----------------------------|
| `ST_IDLE` | Waits for a request |
| `ST_INIT` | Reference clock on, PHY reset asserted |
| `ST_EXIT` | Reference clock off |
| `ST_RELEASE` | Reset released |
| `ST_ARM` | Address 0x10 selected, lane A taken out of idle |
| `ST_WAIT_LOCK` | Waits for PLL lock |
| `ST_WR_TEST` / `ST_WR_TEST_W` | Issues the first write and waits for it to finish |
| `ST_WR_SCC` / `ST_WR_SCC_W` | Issues the second write and waits for it to finish |
| `ST_WAIT_OUT` | Waits for the output flag to read 0 |
| `ST_RESEL` | Reselects address 0x10 |
| `ST_WAIT_RELOCK` | Waits for lock again |
| `ST_FAIL` | Reset reasserted, error pulse |
| `ST_OFF_LANE` | Lane A idled |
| `ST_OFF_RST` | Reset asserted |
| `ST_FINISH` | Done pulse |

Transitions:

- `ST_IDLE` goes to `ST_OFF_LANE`, `ST_RELEASE`, `ST_INIT` or `ST_EXIT`, depending on the request.
- `ST_INIT`, `ST_EXIT` and `ST_OFF_RST` go to `ST_FINISH`.
- `ST_OFF_LANE` goes to `ST_OFF_RST`.
- The power-on chain runs `ST_RELEASE`→`ST_ARM`→`ST_WAIT_LOCK`→`ST_WR_TEST`→`ST_WR_TEST_W`→`ST_WR_SCC`→`ST_WR_SCC_W`→`ST_WAIT_OUT`→`ST_RESEL`→`ST_WAIT_RELOCK`→`ST_FINISH`.
- A timeout in any wait state goes to `ST_FAIL`.
- `ST_FAIL` and `ST_FINISH` return to `ST_IDLE`.

Top module: `phy_pwrup_seq`

## Requirements
- R1: After reset, the outputs are as follows: `phy_rst_o`=1, `refclk_en_o`=0, `lane_idle_off_o`=1, `busy_o`=0, `done_o`=0, `err_o`=0, `err_code_o`=0, `cfg_strobe_o`=0.
- R2: An init request sets `refclk_en_o`=1 and `phy_rst_o`=1, then pulses `done_o`.
- R3: An exit request clears `refclk_en_o`, then pulses `done_o`.
- R4: Power-on sets `phy_rst_o`=0, then sets `cfg_addr_o`=0x10 and `lane_idle_off_o`=0, all before the first lock wait begins.
- R5: A wait samples its condition once every POLL_US×CLK_KHZ/1000 cycles. The first sample is taken on entry. The wait times out TIMEOUT_US/POLL_US intervals after entry.
- R6: After the first lock, the block makes two writes in this order: address 0x10 with data 0x8, then address 0x12 with data 0x8. In each write, address and data are set GAP cycles before `cfg_strobe_o` rises, and the strobe stays high for exactly GAP cycles, where GAP = GAP_US×CLK_KHZ/1000.
- R7: After the writes, the block waits for `pll_out_i`=0, reselects address 0x10 and waits for `pll_locked_i`=1. On success it pulses `done_o` with `err_code_o`=0, and leaves `phy_rst_o`=0.
- R8: A timeout pulses `err_o` and sets `phy_rst_o`=1. The error code is 1 for a lock timeout, 2 for an output-clear timeout and 3 for a relock timeout.
- R9: A power-off request sets `lane_idle_off_o`=1 in an earlier cycle than it sets `phy_rst_o`=1, then pulses `done_o`.
- R10: `busy_o` is high from the cycle after a request is accepted until the cycle in which `done_o` or `err_o` is high. Requests that arrive while busy have no effect.
- R11: When several requests arrive together in idle, power-off wins over power-on, which wins over init, which wins over exit.
- R12: `done_o` and `err_o` are single-cycle pulses that are never high together. `err_code_o` holds its value until the next request is accepted, which clears it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req_i | input | 1 | Request: reference clock on, PHY held in reset |
| exit_req_i | input | 1 | Request: reference clock off |
| pwr_on_req_i | input | 1 | Request: full power-up sequence |
| pwr_off_req_i | input | 1 | Request: idle lane A, then assert PHY reset |
| pll_locked_i | input | 1 | PLL lock flag |
| pll_out_i | input | 1 | PLL output-enable flag (the sequence waits for it to read 0) |
| phy_rst_o | output | 1 | PHY reset, 1 = asserted |
| refclk_en_o | output | 1 | Reference clock enable |
| lane_idle_off_o | output | 1 | Lane A idle-off control, 1 = idle |
| cfg_addr_o | output | 6 | Configuration address |
| cfg_data_o | output | 4 | Configuration data |
| cfg_strobe_o | output | 1 | Configuration write strobe |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Failure pulse |
| err_code_o | output | 2 | 0 = none, 1 = lock, 2 = output-clear, 3 = relock |

## Verification
The power-on sequence runs against a PLL model under random arrival delays. In each run, one stage is chosen at random to never complete, or no stage fails. This separates the three error codes from a clean finish, and it shows whether the writes and the reselect happen only once the stage before them has completed. Directed cases probe the outputs partway through a wait that never ends, which catches a wrong order of release, address selection and lane control. The directed cases also measure how long a lock timeout takes. Further directed cases send requests together, and send requests while the block is busy, which separates the priority order from the rule that busy requests are ignored. A power-on followed by a power-off shows whether lane A is idled before reset is asserted.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam int CFG_AW = 6;
    localparam int CFG_DW = 4;

    localparam logic [CFG_AW-1:0] CFG_LOCK_ADDR = 6'h10;
    localparam logic [CFG_AW-1:0] CFG_TEST_ADDR = 6'h10;
    localparam logic [CFG_AW-1:0] CFG_SCC_ADDR  = 6'h12;
    localparam logic [CFG_DW-1:0] CFG_BIT3      = 4'h8;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_INIT,
        ST_EXIT,
        ST_RELEASE,
        ST_ARM,
        ST_WAIT_LOCK,
        ST_WR_TEST,
        ST_WR_TEST_W,
        ST_WR_SCC,
        ST_WR_SCC_W,
        ST_WAIT_OUT,
        ST_RESEL,
        ST_WAIT_RELOCK,
        ST_FAIL,
        ST_OFF_LANE,
        ST_OFF_RST,
        ST_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_LOCK   = 2'd1,
        ERR_OUTCLR = 2'd2,
        ERR_RELOCK = 2'd3
    } seq_err_t;

endpackage

// File: rtl/seq_poll_timer.sv
module seq_poll_timer #(
    parameter int POLL_CYC  = 4,
    parameter int MAX_POLLS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    output logic sample_o,
    output logic expired_o
);

    localparam int TW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
    localparam int PW = $clog2(MAX_POLLS + 1);

    logic [TW-1:0] tick_q;
    logic [PW-1:0] poll_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            poll_q <= '0;
        end else if (!active_i) begin
            tick_q <= '0;
            poll_q <= '0;
        end else if (tick_q == '0) begin
            tick_q <= TW'(POLL_CYC - 1);
            if (poll_q != PW'(MAX_POLLS))
                poll_q <= poll_q + 1'b1;
        end else begin
            tick_q <= tick_q - 1'b1;
        end
    end

    assign sample_o  = active_i && (tick_q == '0);
    assign expired_o = sample_o && (poll_q == PW'(MAX_POLLS));

endmodule

// File: rtl/seq_cfg_port.sv
module seq_cfg_port
    import phy_seq_pkg::*;
#(
    parameter int GAP_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [CFG_AW-1:0] addr_i,
    input  logic [CFG_DW-1:0] data_i,
    output logic [CFG_AW-1:0] addr_o,
    output logic [CFG_DW-1:0] data_o,
    output logic              strobe_o,
    output logic              done_o
);

    localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

    typedef enum logic [1:0] {CP_IDLE, CP_SETUP, CP_HOLD} cp_phase_t;

    cp_phase_t         phase_q;
    logic [GW-1:0]     cnt_q;
    logic [CFG_AW-1:0] addr_q;
    logic [CFG_DW-1:0] data_q;
    logic              strobe_q;
    logic              done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= CP_IDLE;
            cnt_q    <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            strobe_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                CP_IDLE: begin
                    if (wr_i) begin
                        addr_q  <= addr_i;
                        data_q  <= data_i;
                        cnt_q   <= GW'(GAP_CYC - 1);
                        phase_q <= CP_SETUP;
                    end else if (sel_i) begin
                        addr_q <= addr_i;
                    end
                end
                CP_SETUP: begin
                    if (cnt_q == '0) begin
                        strobe_q <= 1'b1;
                        cnt_q    <= GW'(GAP_CYC - 1);
                        phase_q  <= CP_HOLD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                CP_HOLD: begin
                    if (cnt_q == '0) begin
                        strobe_q <= 1'b0;
                        done_q   <= 1'b1;
                        phase_q  <= CP_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: phase_q <= CP_IDLE;
            endcase
        end
    end

    assign addr_o   = addr_q;
    assign data_o   = data_q;
    assign strobe_o = strobe_q;
    assign done_o   = done_q;

endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
    import phy_seq_pkg::*;
#(
    parameter int CLK_KHZ    = 100000,
    parameter int POLL_US    = 50,
    parameter int TIMEOUT_US = 20000,
    parameter int GAP_US     = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_req_i,
    input  logic        exit_req_i,
    input  logic        pwr_on_req_i,
    input  logic        pwr_off_req_i,
    input  logic        pll_locked_i,
    input  logic        pll_out_i,
    output logic        phy_rst_o,
    output logic        refclk_en_o,
    output logic        lane_idle_off_o,
    output logic [5:0]  cfg_addr_o,
    output logic [3:0]  cfg_data_o,
    output logic        cfg_strobe_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o,
    output logic [1:0]  err_code_o
);

    localparam int POLL_RAW  = CLK_KHZ * POLL_US / 1000;
    localparam int POLL_CYC  = (POLL_RAW < 1) ? 1 : POLL_RAW;
    localparam int POLL_NUM  = TIMEOUT_US / POLL_US;
    localparam int MAX_POLLS = (POLL_NUM < 1) ? 1 : POLL_NUM;
    localparam int GAP_RAW   = CLK_KHZ * GAP_US / 1000;
    localparam int GAP_CYC   = (GAP_RAW < 1) ? 1 : GAP_RAW;

    seq_state_t        state_q, state_d;
    logic              tmr_active, tmr_sample, tmr_expired;
    logic              cp_sel, cp_wr, cp_done;
    logic [CFG_AW-1:0] cp_addr;

    logic       phy_rst_q, refclk_q, lane_off_q, done_q, err_q;
    logic [1:0] err_code_q;

    // wait timer: restarted whenever the FSM leaves a wait state
    assign tmr_active = (state_q == ST_WAIT_LOCK) || (state_q == ST_WAIT_OUT) ||
                        (state_q == ST_WAIT_RELOCK);

    seq_poll_timer #(
        .POLL_CYC  (POLL_CYC),
        .MAX_POLLS (MAX_POLLS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (tmr_active),
        .sample_o  (tmr_sample),
        .expired_o (tmr_expired)
    );

    assign cp_sel  = (state_q == ST_ARM) || (state_q == ST_RESEL);
    assign cp_wr   = (state_q == ST_WR_TEST) || (state_q == ST_WR_SCC);
    assign cp_addr = (state_q == ST_WR_SCC) ? CFG_SCC_ADDR :
                     (state_q == ST_WR_TEST) ? CFG_TEST_ADDR : CFG_LOCK_ADDR;

    seq_cfg_port #(
        .GAP_CYC (GAP_CYC)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (cp_sel),
        .wr_i     (cp_wr),
        .addr_i   (cp_addr),
        .data_i   (CFG_BIT3),
        .addr_o   (cfg_addr_o),
        .data_o   (cfg_data_o),
        .strobe_o (cfg_strobe_o),
        .done_o   (cp_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pwr_off_req_i)     state_d = ST_OFF_LANE;
                else if (pwr_on_req_i) state_d = ST_RELEASE;
                else if (init_req_i)   state_d = ST_INIT;
                else if (exit_req_i)   state_d = ST_EXIT;
            end
            ST_INIT:      state_d = ST_FINISH;
            ST_EXIT:      state_d = ST_FINISH;
            ST_RELEASE:   state_d = ST_ARM;
            ST_ARM:       state_d = ST_WAIT_LOCK;
            ST_WAIT_LOCK: begin
                if (tmr_sample && pll_locked_i) state_d = ST_WR_TEST;
                else if (tmr_expired)           state_d = ST_FAIL;
            end
            ST_WR_TEST:   state_d = ST_WR_TEST_W;
            ST_WR_TEST_W: if (cp_done) state_d = ST_WR_SCC;
            ST_WR_SCC:    state_d = ST_WR_SCC_W;
            ST_WR_SCC_W:  if (cp_done) state_d = ST_WAIT_OUT;
            ST_WAIT_OUT: begin
                if (tmr_sample && !pll_out_i) state_d = ST_RESEL;
                else if (tmr_expired)         state_d = ST_FAIL;
            end
            ST_RESEL:     state_d = ST_WAIT_RELOCK;
            ST_WAIT_RELOCK: begin
                if (tmr_sample && pll_locked_i) state_d = ST_FINISH;
                else if (tmr_expired)           state_d = ST_FAIL;
            end
            ST_FAIL:      state_d = ST_IDLE;
            ST_OFF_LANE:  state_d = ST_OFF_RST;
            ST_OFF_RST:   state_d = ST_FINISH;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phy_rst_q  <= 1'b1;
            refclk_q   <= 1'b0;
            lane_off_q <= 1'b1;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            err_code_q <= ERR_NONE;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE:        if (state_d != ST_IDLE) err_code_q <= ERR_NONE;
                ST_INIT: begin
                    refclk_q  <= 1'b1;
                    phy_rst_q <= 1'b1;
                end
                ST_EXIT:        refclk_q   <= 1'b0;
                ST_RELEASE:     phy_rst_q  <= 1'b0;
                ST_ARM:         lane_off_q <= 1'b0;
                ST_WAIT_LOCK:   if (state_d == ST_FAIL) err_code_q <= ERR_LOCK;
                ST_WAIT_OUT:    if (state_d == ST_FAIL) err_code_q <= ERR_OUTCLR;
                ST_WAIT_RELOCK: if (state_d == ST_FAIL) err_code_q <= ERR_RELOCK;
                ST_FAIL: begin
                    phy_rst_q <= 1'b1;
                    err_q     <= 1'b1;
                end
                ST_OFF_LANE:    lane_off_q <= 1'b1;
                ST_OFF_RST:     phy_rst_q  <= 1'b1;
                ST_FINISH:      done_q     <= 1'b1;
                default: ;
            endcase
        end
    end

    assign phy_rst_o       = phy_rst_q;
    assign refclk_en_o     = refclk_q;
    assign lane_idle_off_o = lane_off_q;
    assign busy_o          = (state_q != ST_IDLE);
    assign done_o          = done_q;
    assign err_o           = err_q;
    assign err_code_o      = err_code_q;

endmodule

// File: rtl/phy_pwrup_seq_chk.sv
module phy_pwrup_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       phy_rst_o,
    input logic [5:0] cfg_addr_o,
    input logic [3:0] cfg_data_o,
    input logic       cfg_strobe_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o,
    input logic [1:0] err_code_o
);

    assert_done_err_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, err_o}));

    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |=> !(done_o || err_o));

    assert_end_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |-> !busy_o);

    assert_busy_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o || err_o));

    assert_err_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (err_code_o != 2'd0) && phy_rst_o);

    assert_strobe_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_strobe_o |-> busy_o && $stable(cfg_addr_o) && $stable(cfg_data_o));

endmodule

bind phy_pwrup_seq phy_pwrup_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .phy_rst_o    (phy_rst_o),
    .cfg_addr_o   (cfg_addr_o),
    .cfg_data_o   (cfg_data_o),
    .cfg_strobe_o (cfg_strobe_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .err_code_o   (err_code_o)
);

// File: tb/phy_pwrup_seq_bench.sv
module phy_pwrup_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_KHZ    = 1000;
    localparam int POLL_US    = 4;
    localparam int TIMEOUT_US = 32;
    localparam int GAP_US     = 2;
    localparam int POLL       = POLL_US;            // cycles at 1 MHz
    localparam int WINDOW     = TIMEOUT_US;         // cycles
    localparam int GAP        = GAP_US;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_req = 0, exit_req = 0, on_req = 0, off_req = 0;
    logic pll_locked = 0, pll_out = 1;
    logic       phy_rst_o, refclk_en_o, lane_idle_off_o, cfg_strobe_o;
    logic [5:0] cfg_addr_o;
    logic [3:0] cfg_data_o;
    logic       busy_o, done_o, err_o;
    logic [1:0] err_code_o;

    phy_pwrup_seq #(
        .CLK_KHZ(CLK_KHZ), .POLL_US(POLL_US), .TIMEOUT_US(TIMEOUT_US), .GAP_US(GAP_US)
    ) u_phy_pwrup_seq (
        .clk(clk), .rst_n(rst_n),
        .init_req_i(init_req), .exit_req_i(exit_req),
        .pwr_on_req_i(on_req), .pwr_off_req_i(off_req),
        .pll_locked_i(pll_locked), .pll_out_i(pll_out),
        .phy_rst_o(phy_rst_o), .refclk_en_o(refclk_en_o), .lane_idle_off_o(lane_idle_off_o),
        .cfg_addr_o(cfg_addr_o), .cfg_data_o(cfg_data_o), .cfg_strobe_o(cfg_strobe_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_err = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // monitors
    int wr_n = 0;
    int wr_addr [4];
    int wr_data [4];
    int hi_len = 0;
    logic prev_strobe = 0, prev_lane = 1, prev_rst = 1;
    int lane_rise_cyc = -1, rst_rise_cyc = -1, rst_fall_n = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cfg_strobe_o && !prev_strobe) begin
            if (wr_n < 4) begin
                wr_addr[wr_n] = int'(cfg_addr_o);
                wr_data[wr_n] = int'(cfg_data_o);
            end
            wr_n++;
            hi_len = 1;
        end else if (cfg_strobe_o) begin
            hi_len++;
        end else if (prev_strobe) begin
            chk(hi_len == GAP, "R6 strobe width", hi_len, GAP);
        end
        if (lane_idle_off_o && !prev_lane) lane_rise_cyc = cyc;
        if (phy_rst_o && !prev_rst) rst_rise_cyc = cyc;
        if (!phy_rst_o && prev_rst) rst_fall_n++;
        prev_strobe = cfg_strobe_o;
        prev_lane   = lane_idle_off_o;
        prev_rst    = phy_rst_o;
    end

    // PLL model
    int phase = 0, pcnt = 0;
    int t_lock = 0, t_out = 0, t_rl = 0;
    always @(negedge clk) begin
        case (phase)
            1: begin
                pcnt++;
                pll_out    = 1'b1;
                pll_locked = (t_lock >= 0) && (pcnt > t_lock);
                if (wr_n >= 2) begin
                    phase = 2; pcnt = 0; pll_locked = 1'b0;
                end
            end
            2: begin
                pcnt++;
                pll_out    = !((t_out >= 0) && (pcnt > t_out));
                pll_locked = (t_out >= 0) && (t_rl >= 0) && (pcnt > t_out + t_rl);
            end
            default: begin
                pll_locked = 1'b0;
                pll_out    = 1'b1;
            end
        endcase
    end

    task automatic pulse(input bit on, input bit off, input bit ini, input bit ext);
        @(negedge clk);
        on_req = on; off_req = off; init_req = ini; exit_req = ext;
        @(negedge clk);
        on_req = 0; off_req = 0; init_req = 0; exit_req = 0;
    endtask

    task automatic wait_end(output bit d, output bit e, output int code, output int dur);
        int n = 0;
        d = 0; e = 0; code = 0;
        while (!(done_o || err_o) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        d = done_o; e = err_o; code = int'(err_code_o); dur = n;
        if (n >= 2000) chk(0, "R10 operation never ended", n, 0);
        @(negedge clk);
        chk(!done_o && !err_o, "R12 end pulse one cycle", int'({done_o, err_o}), 0);
    endtask

    function automatic int exp_code(input int tl, input int to, input int tr);
        if (tl < 0) return 1;
        if (to < 0) return 2;
        if (tr < 0) return 3;
        return 0;
    endfunction

    task automatic run_on(input int tl, input int to, input int tr, input string tag);
        bit d, e; int code, dur, ec;
        t_lock = tl; t_out = to; t_rl = tr;
        wr_n = 0; pcnt = 0; phase = 1;
        pulse(1, 0, 0, 0);
        chk(busy_o == 1'b1, {tag, " R10 busy after accept"}, int'(busy_o), 1);
        wait_end(d, e, code, dur);
        phase = 0;
        ec = exp_code(tl, to, tr);
        chk(code == ec, {tag, " R8 error code"}, code, ec);
        chk(d == (ec == 0), {tag, " R7 done"}, int'(d), int'(ec == 0));
        chk(e == (ec != 0), {tag, " R8 err"}, int'(e), int'(ec != 0));
        chk(phy_rst_o == (ec != 0), {tag, " R8 phy reset state"}, int'(phy_rst_o), int'(ec != 0));
        chk(wr_n == ((ec == 1) ? 0 : 2), {tag, " R6 write count"}, wr_n, (ec == 1) ? 0 : 2);
        if (ec != 1 && wr_n == 2) begin
            chk(wr_addr[0] == 'h10 && wr_data[0] == 8, {tag, " R6 first write"}, wr_addr[0], 'h10);
            chk(wr_addr[1] == 'h12 && wr_data[1] == 8, {tag, " R6 second write"}, wr_addr[1], 'h12);
        end
        if (ec == 0)
            chk(cfg_addr_o == 6'h10 && !lane_idle_off_o, {tag, " R7 reselect"}, int'(cfg_addr_o), 'h10);
        chk(busy_o == 1'b0, {tag, " R10 idle after end"}, int'(busy_o), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : stim
        bit d, e; int code, dur, fall0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(phy_rst_o && !refclk_en_o && lane_idle_off_o, "R1 reset outputs",
            int'({phy_rst_o, refclk_en_o, lane_idle_off_o}), 5);
        chk(!busy_o && !done_o && !err_o && err_code_o == 0 && !cfg_strobe_o, "R1 reset status",
            int'({busy_o, done_o, err_o, err_code_o, cfg_strobe_o}), 0);

        // R2 init
        pulse(0, 0, 1, 0);
        wait_end(d, e, code, dur);
        chk(d && refclk_en_o && phy_rst_o, "R2 init", int'({d, refclk_en_o, phy_rst_o}), 7);

        // R4 / R5: lock never arrives, probe mid-wait and measure timeout
        t_lock = -1; t_out = 0; t_rl = 0; wr_n = 0; pcnt = 0; phase = 1;
        pulse(1, 0, 0, 0);
        repeat (8) @(negedge clk);
        chk(!phy_rst_o, "R4 reset released", int'(phy_rst_o), 0);
        chk(!lane_idle_off_o, "R4 lane A out of idle", int'(lane_idle_off_o), 0);
        chk(cfg_addr_o == 6'h10, "R4 address 0x10 selected", int'(cfg_addr_o), 'h10);
        wait_end(d, e, code, dur);
        phase = 0;
        dur += 8;
        chk(dur >= WINDOW && dur <= WINDOW + 6, "R5 lock timeout duration", dur, WINDOW + 3);
        chk(e && code == 1 && phy_rst_o, "R8 lock timeout code", code, 1);

        // R12 code held, cleared on next accept
        repeat (5) @(negedge clk);
        chk(err_code_o == 2'd1, "R12 code held in idle", int'(err_code_o), 1);

        // directed successes and failures
        run_on(0, 0, 0, "dir fast");
        run_on(3, 5, 2, "dir slow");
        run_on(2, -1, 0, "dir outclr");
        run_on(1, 1, -1, "dir relock");

        // constrained random
        for (int i = 0; i < 12; i++) begin
            int st, a, b, c;
            st = int'($urandom_range(0, 3));
            a = int'($urandom_range(0, 12));
            b = int'($urandom_range(0, 12));
            c = int'($urandom_range(0, 12));
            if (st == 1) a = -1;
            if (st == 2) b = -1;
            if (st == 3) c = -1;
            run_on(a, b, c, $sformatf("rnd%0d", i));
        end

        // R9 power-off after a clean power-on
        run_on(0, 0, 0, "pre-off");
        lane_rise_cyc = -1; rst_rise_cyc = -1;
        pulse(0, 1, 0, 0);
        wait_end(d, e, code, dur);
        chk(d && lane_idle_off_o && phy_rst_o, "R9 power-off end state",
            int'({d, lane_idle_off_o, phy_rst_o}), 7);
        chk(lane_rise_cyc >= 0 && rst_rise_cyc > lane_rise_cyc, "R9 lane idled before reset",
            rst_rise_cyc - lane_rise_cyc, 1);

        // R3 exit
        pulse(0, 0, 0, 1);
        wait_end(d, e, code, dur);
        chk(d && !refclk_en_o, "R3 exit", int'(refclk_en_o), 0);

        // R10 requests while busy are ignored
        t_lock = 2; t_out = 2; t_rl = 2; wr_n = 0; pcnt = 0; phase = 1;
        pulse(1, 0, 0, 0);
        repeat (3) @(negedge clk);
        pulse(0, 0, 1, 0);
        pulse(0, 1, 0, 0);
        wait_end(d, e, code, dur);
        phase = 0;
        chk(d && code == 0 && !phy_rst_o, "R10 busy power-on unaffected", code, 0);
        chk(!refclk_en_o && !lane_idle_off_o, "R10 init/off ignored while busy",
            int'({refclk_en_o, lane_idle_off_o}), 0);

        // R11 priority: off beats on
        pulse(0, 1, 0, 0);
        wait_end(d, e, code, dur);
        fall0 = rst_fall_n; wr_n = 0; t_lock = 0; pcnt = 0; phase = 1;
        pulse(1, 1, 0, 0);
        wait_end(d, e, code, dur);
        phase = 0;
        chk(d && rst_fall_n == fall0 && wr_n == 0, "R11 power-off wins over power-on",
            rst_fall_n - fall0, 0);
        // R11 priority: init beats exit
        pulse(0, 0, 1, 1);
        wait_end(d, e, code, dur);
        chk(d && refclk_en_o, "R11 init wins over exit", int'(refclk_en_o), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule